// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives serial audio as a slave. It samples a bit clock, a frame clock and a set of data lines with its own system clock, and it rebuilds parallel left and right samples for up to three stereo channels. A static control port sets the framing, the word length and the polarity of both serial clocks. Each channel's sample pair is presented as 32-bit left-aligned words, and a one-cycle valid strobe marks each new pair. The pair is released only once both the left word and the right word have been received.

In the three stereo framings each channel has its own data line. In the two pulse-framed modes all six words arrive back to back on data line 0. The block also measures the distance between rising frame-clock edges. When that distance is exactly 32 bit clocks, it switches to 16-bit words. The serial inputs are expected to be synchronous to the system clock already. The bit clock must be at most a quarter of the system clock rate.

Top module: `aud_rx_top`

## Requirements
- R1: After reset all valid strobes are low and all sample outputs read zero.
- R2: Format code 000 (left-justified): the MSB is taken on the first rising bit clock edge of a frame-clock half, and the half with the frame clock high carries the left word.
- R3: Format code 010 (I2S): the MSB is taken on the second rising bit clock edge after a frame-clock transition, and the half with the frame clock low carries the left word.
- R4: Format code 001 (right-justified): the word is made of the last N bits before a frame-clock transition, and the half with the frame clock high carries the left word.
- R5: Format codes 011 and 100 (pulse-framed): a frame starts at a rising frame-clock edge. With code 100 the MSB is on that same edge; with code 011 it comes one bit clock later. Six words follow with no gap on data line 0, in the order ch0 left, ch0 right, ch1 left, ch1 right, ch2 left, ch2 right.
- R6: Word-length code 00 gives 16 bits, 01 gives 20, 10 gives 24 and 11 gives 32. Bits that follow the word inside the same half are ignored.
- R7: In the right-justified format, word-length code 11 yields 24-bit words.
- R8: Each sample is presented left-aligned in 32 bits, and the bits below the word length read zero.
- R9: When exactly 32 bit clocks separate two rising frame-clock edges, words completed after the second of those edges are 16 bits long in formats 000, 001 and 010.
- R10: The frame-clock invert input flips the frame clock level, and the bit-clock invert input makes the falling physical edge the sampling edge.
- R11: A channel's valid strobe lasts one cycle. It fires when that channel's right word completes after its left word, and a right word with no preceding left word is dropped.
- R12: In formats 000, 001 and 010, channel k takes its data from data line k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 3 | Framing select (see R2 to R5) |
| wl_i | input | 2 | Word-length select (see R6) |
| lr_inv_i | input | 1 | Invert the frame clock |
| bclk_inv_i | input | 1 | Invert the bit clock |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Serial frame (left/right) clock |
| din_i | input | NCH | Serial data lines, one per channel |
| smp_l_o | output | NCH x 32 | Left sample per channel, left-aligned |
| smp_r_o | output | NCH x 32 | Right sample per channel, left-aligned |
| smp_vld_o | output | NCH | One-cycle valid strobe per channel |

## Verification
Frame-length measurement and the start of a word can fall on the same bit clock edge. In the left-justified format, the rising frame-clock edge that completes a 32-clock measurement is also the edge that takes the MSB of the next left word. The bench provokes this with a run of 32-clock frames at word-length code 10. It expects no output for the first frame and 16-bit words from the second frame onwards. Any leftover 24-bit capture would show up as a missing or mismatched sample in the bench's per-channel queues.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int SMP_W = 32;
  localparam int LEN_W = 6;

  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_RJ   = 3'd1,
    FMT_I2S  = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmt_e;

  function automatic logic is_pulse_fmt(fmt_e f);
    return (f == FMT_DSPA) || (f == FMT_DSPB);
  endfunction

  // Effective word length from the control code, the format and the 32-clock detection.
  function automatic logic [LEN_W-1:0] eff_len(logic [1:0] code, fmt_e f, logic short32);
    logic [LEN_W-1:0] n;
    case (code)
      2'd0: n = 6'd16;
      2'd1: n = 6'd20;
      2'd2: n = 6'd24;
      default: n = 6'd32;
    endcase
    if (f == FMT_RJ && code == 2'd3) n = 6'd24;
    if (short32 && !is_pulse_fmt(f)) n = 6'd16;
    return n;
  endfunction

  // The shift register holds the word in its low n bits; move it to the top, zero below.
  function automatic logic [SMP_W-1:0] left_align(logic [SMP_W-1:0] v, logic [LEN_W-1:0] n);
    return v << (6'd32 - n);
  endfunction
endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lr_inv_i,
  input  logic           bclk_inv_i,
  input  logic           bclk_i,
  input  logic           lrclk_i,
  input  logic [NCH-1:0] din_i,
  output logic           rise_o,
  output logic           lr_o,
  output logic [NCH-1:0] din_o
);
  logic bclk_e, bclk_q;

  assign bclk_e = bclk_i ^ bclk_inv_i;
  assign rise_o = bclk_e & ~bclk_q;
  assign lr_o   = lrclk_i ^ lr_inv_i;
  assign din_o  = din_i;

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk_e;
  end

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R10
endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
  import aud_rx_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  fmt_e                      fmt_i,
  input  logic [1:0]                wl_i,
  input  logic                      rise_i,
  input  logic                      lr_i,
  input  logic [NCH-1:0]            din_i,
  output logic [NCH-1:0]            wdone_o,
  output logic                      wleft_o,
  output logic [NCH-1:0][SMP_W-1:0] wdata_o
);
  localparam int NSLOT = 2 * NCH;
  localparam int SLW   = $clog2(NSLOT);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic                      lr_prev, short_q, run_q, side_q;
  logic [CW-1:0]             cnt_q, fcnt_q, cnt_new, off;
  logic [LEN_W-1:0]          bpos_q, idx, len;
  logic [SLW-1:0]            slot_q, sl;
  logic [NCH-1:0][SMP_W-1:0] sh_q, sh_n;
  logic trans, rise_lr, pulse, rj, start, begin_w, cap, side, wfin;

  always_comb begin
    trans   = rise_i & (lr_i != lr_prev);
    rise_lr = trans & lr_i;
    pulse   = is_pulse_fmt(fmt_i);
    rj      = (fmt_i == FMT_RJ);
    start   = pulse ? rise_lr : trans;
    cnt_new = start ? '0 : ((cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1);
    off     = (fmt_i == FMT_I2S || fmt_i == FMT_DSPA) ? CW'(1) : '0;
    len     = eff_len(wl_i, fmt_i, short_q);
    begin_w = rise_i & ~rj & (cnt_new == off);
    cap     = begin_w | (rise_i & ~rj & run_q);
    idx     = begin_w ? '0 : bpos_q;
    sl      = begin_w ? '0 : slot_q;
    side    = begin_w ? ((fmt_i == FMT_I2S) ? ~lr_i : lr_i) : side_q;
    wfin    = cap & (idx == len - 6'd1);
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign sh_n[k] = {sh_q[k][SMP_W-2:0], din_i[k]};
    assign wdone_o[k] = rj    ? trans :
                        pulse ? (wfin & (sl[SLW-1:1] == (SLW-1)'(k))) : wfin;
    assign wdata_o[k] = rj    ? left_align(sh_q[k], len) :
                        pulse ? left_align(sh_n[0], len) : left_align(sh_n[k], len);
  end

  assign wleft_o = rj ? lr_prev : (pulse ? ~sl[0] : side);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_prev <= 1'b0;
      cnt_q   <= CMAX;
      fcnt_q  <= '0;
      short_q <= 1'b0;
      run_q   <= 1'b0;
      bpos_q  <= '0;
      slot_q  <= '0;
      side_q  <= 1'b0;
      sh_q    <= '0;
    end else if (rise_i) begin
      lr_prev <= lr_i;
      cnt_q   <= cnt_new;
      sh_q    <= sh_n;
      fcnt_q  <= rise_lr ? CW'(1) : ((fcnt_q == CMAX) ? fcnt_q : fcnt_q + 1'b1);
      if (rise_lr) short_q <= (fcnt_q == CW'(32));
      if (cap) begin
        side_q <= side;
        if (idx < len - 6'd1) begin
          run_q  <= 1'b1;
          bpos_q <= idx + 1'b1;
          slot_q <= sl;
        end else if (wfin && pulse && sl < SLW'(NSLOT - 1)) begin
          run_q  <= 1'b1;
          bpos_q <= '0;
          slot_q <= sl + 1'b1;
        end else begin
          run_q  <= 1'b0;
        end
      end
    end
  end

  AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|wdone_o) |-> rise_i); // R2
  AST_PULSE_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $onehot0(wdone_o)); // R5
  AST_RJ_AT_TRANSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (rj && (|wdone_o)) |=> (lr_prev != $past(lr_prev))); // R4
  AST_SHORT_AT_RISING: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(short_q) |-> $past(rise_lr)); // R9
endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair
  import aud_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdone_i,
  input  logic             wleft_i,
  input  logic [SMP_W-1:0] wdata_i,
  output logic [SMP_W-1:0] smp_l_o,
  output logic [SMP_W-1:0] smp_r_o,
  output logic             vld_o
);
  logic [SMP_W-1:0] pend_q;
  logic             got_l_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      got_l_q <= 1'b0;
      smp_l_o <= '0;
      smp_r_o <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (wdone_i && wleft_i) begin
        pend_q  <= wdata_i;
        got_l_q <= 1'b1;
      end else if (wdone_i && got_l_q) begin
        smp_l_o <= pend_q;
        smp_r_o <= wdata_i;
        vld_o   <= 1'b1;
        got_l_q <= 1'b0;
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o); // R11
  AST_VLD_AFTER_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(got_l_q)); // R11
endmodule

// File: rtl/aud_rx_top.sv
module aud_rx_top
  import aud_rx_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                fmt_i,
  input  logic [1:0]                wl_i,
  input  logic                      lr_inv_i,
  input  logic                      bclk_inv_i,
  input  logic                      bclk_i,
  input  logic                      lrclk_i,
  input  logic [NCH-1:0]            din_i,
  output logic [NCH-1:0][SMP_W-1:0] smp_l_o,
  output logic [NCH-1:0][SMP_W-1:0] smp_r_o,
  output logic [NCH-1:0]            smp_vld_o
);
  logic                      rise, lr, wleft;
  logic [NCH-1:0]            din_s, wdone;
  logic [NCH-1:0][SMP_W-1:0] wdata;

  aud_rx_edge #(.NCH(NCH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lr_inv_i(lr_inv_i), .bclk_inv_i(bclk_inv_i),
    .bclk_i(bclk_i), .lrclk_i(lrclk_i), .din_i(din_i),
    .rise_o(rise), .lr_o(lr), .din_o(din_s)
  );

  aud_rx_frame #(.NCH(NCH), .CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_e'(fmt_i)), .wl_i(wl_i),
    .rise_i(rise), .lr_i(lr), .din_i(din_s),
    .wdone_o(wdone), .wleft_o(wleft), .wdata_o(wdata)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_pair
    aud_rx_pair u_pair (
      .clk(clk), .rst_n(rst_n), .wdone_i(wdone[k]), .wleft_i(wleft),
      .wdata_i(wdata[k]), .smp_l_o(smp_l_o[k]), .smp_r_o(smp_r_o[k]),
      .vld_o(smp_vld_o[k])
    );
  end
endmodule

// File: tb/sim_aud_rx_top.sv
module sim_aud_rx_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] fmt_i = 3'd0;
  logic [1:0] wl_i = 2'd0;
  logic lr_inv_i = 1'b0, bclk_inv_i = 1'b0, bclk_i = 1'b0, lrclk_i = 1'b0;
  logic [2:0] din_i = 3'd0;
  logic [2:0][31:0] smp_l_o, smp_r_o;
  logic [2:0] smp_vld_o;

  int checks = 0, errors = 0, cyc = 0;
  string cur_tag = "R1";
  logic [63:0] exp_q [3][$];
  logic [3:0]  strm [0:2047];

  aud_rx_top u0 (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles, expected fewer than 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Reference comparison on every clock: each strobe must match the next expected pair.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int ch = 0; ch < 3; ch++) begin
        if (smp_vld_o[ch]) begin
          checks++;
          if (exp_q[ch].size() == 0) begin
            errors++;
            $display("FAIL %s ch%0d unexpected strobe: actual %h_%h, expected none",
                     cur_tag, ch, smp_l_o[ch], smp_r_o[ch]);
          end else begin
            logic [63:0] e;
            e = exp_q[ch].pop_front();
            if ({smp_l_o[ch], smp_r_o[ch]} !== e) begin
              errors++;
              $display("FAIL %s ch%0d sample: actual %h_%h, expected %h_%h",
                       cur_tag, ch, smp_l_o[ch], smp_r_o[ch], e[63:32], e[31:0]);
            end
          end
        end
      end
    end
  end

  function automatic int blen(int code, int fmt, bit shortf);
    int n;
    n = (code == 0) ? 16 : (code == 1) ? 20 : (code == 2) ? 24 : 32;
    if (fmt == 1 && code == 3) n = 24;   // R7
    if (shortf && fmt < 3) n = 16;       // R9
    return n;
  endfunction

  function automatic logic [31:0] topmask(int n);
    return ~(32'hFFFF_FFFF >> n);        // R8: low bits zero
  endfunction

  task automatic drive_bit(logic [3:0] e);
    @(negedge clk);
    bclk_i  = bclk_inv_i;
    lrclk_i = e[3] ^ lr_inv_i;
    din_i   = e[2:0];
    repeat (2) @(negedge clk);
    bclk_i = ~bclk_inv_i;
    @(negedge clk);
  endtask

  task automatic run_sec(int fmt, int wlc, int half, int nfr, bit li, bit bi, bit autod, string tag);
    int n, L, off, flen, base, pos, la;
    logic [31:0] w;
    logic [31:0] wl [3];
    cur_tag = "R1";
    rst_n = 1'b0;
    fmt_i = 3'(fmt); wl_i = 2'(wlc); lr_inv_i = li; bclk_inv_i = bi;
    bclk_i = bi; lrclk_i = li; din_i = 3'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (smp_vld_o !== 3'b000 || smp_l_o !== '0 || smp_r_o !== '0) begin
      errors++;
      $display("FAIL R1 reset state: actual vld %b, expected 000 with zero samples", smp_vld_o);
    end
    cur_tag = tag;
    n = 0;
    if (fmt < 3) begin
      la = (fmt == 2) ? 0 : 1;
      for (int i = 0; i < 4; i++) begin strm[n] = {1'(~la), 3'($urandom)}; n++; end
      for (int f = 0; f < nfr; f++)
        for (int p = 0; p < 2 * half; p++) begin
          strm[n] = {(p < half) ? 1'(la) : 1'(~la), 3'($urandom)}; n++;
        end
      for (int i = 0; i < 4; i++) begin strm[n] = {1'(la), 3'($urandom)}; n++; end
      for (int f = 0; f < nfr; f++) begin
        L = blen(wlc, fmt, autod && f > 0);
        for (int ch = 0; ch < 3; ch++) begin
          for (int h = 0; h < 2; h++) begin
            w = $urandom;
            base = 4 + f * 2 * half + h * half;
            pos = base + ((fmt == 0) ? 0 : (fmt == 2) ? 1 : half - L);
            for (int i = 0; i < L; i++) strm[pos + i][ch] = w[31 - i];   // R12
            wl[h] = w & topmask(L);
          end
          if (!(autod && f == 0)) exp_q[ch].push_back({wl[0], wl[1]});
        end
      end
    end else begin
      L = blen(wlc, fmt, 1'b0);
      off = (fmt == 3) ? 1 : 0;
      flen = 6 * L + 8;
      for (int i = 0; i < 4; i++) begin strm[n] = {1'b0, 3'($urandom)}; n++; end
      for (int f = 0; f < nfr; f++)
        for (int p = 0; p < flen; p++) begin
          strm[n] = {(p == 0) ? 1'b1 : 1'b0, 3'($urandom)}; n++;
        end
      for (int i = 0; i < 4; i++) begin strm[n] = {1'b0, 3'($urandom)}; n++; end
      for (int f = 0; f < nfr; f++)
        for (int ch = 0; ch < 3; ch++) begin
          for (int h = 0; h < 2; h++) begin
            w = $urandom;
            pos = 4 + f * flen + off + (2 * ch + h) * L;
            for (int i = 0; i < L; i++) strm[pos + i][0] = w[31 - i];
            wl[h] = w & topmask(L);
          end
          exp_q[ch].push_back({wl[0], wl[1]});
        end
    end
    for (int i = 0; i < n; i++) drive_bit(strm[i]);
    repeat (40) @(negedge clk);
    for (int ch = 0; ch < 3; ch++) begin
      checks++;
      if (exp_q[ch].size() != 0) begin
        errors++;
        $display("FAIL R11 %s ch%0d missing strobes: actual %0d pending, expected 0",
                 tag, ch, exp_q[ch].size());
        exp_q[ch].delete();
      end
    end
  endtask

  initial begin
    run_sec(2, 2, 32, 2, 0, 0, 0, "R3 I2S 24-bit");
    run_sec(0, 0, 32, 2, 0, 0, 0, "R2 R6 R8 LJ 16-bit with trailing bits");
    run_sec(1, 3, 32, 2, 0, 0, 0, "R4 R7 RJ 32 forced to 24");
    run_sec(1, 1, 24, 2, 0, 0, 0, "R4 R6 RJ 20-bit");
    run_sec(3, 0, 0, 2, 0, 0, 0, "R5 pulse mode A 16-bit");
    run_sec(4, 2, 0, 2, 0, 0, 0, "R5 pulse mode B 24-bit");
    run_sec(0, 3, 32, 2, 1, 1, 0, "R10 LJ 32-bit inverted clocks");
    run_sec(2, 1, 32, 2, 1, 0, 0, "R10 R12 I2S 20-bit inverted frame clock");
    run_sec(0, 2, 16, 3, 0, 0, 1, "R9 32-clock frame detection");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule